// File: doc/BRIEF.md
# Quadrature NCO with Binary Phase Select

This block is the phase engine of a direct digital synthesizer. A 48-bit accumulator adds the active frequency word on every clock. One of two 14-bit phase offsets is added to the accumulator, and the top 12 bits of the result form the in-phase output. The quadrature output comes from the same sum with a quarter turn added. A single data input chooses which offset is added. Toggling that input therefore flips the carrier between two programmed phases on both outputs at once, which gives binary phase shift keying. For higher-order keying, software can leave the input fixed and rewrite an offset between commits.

Software loads shadow registers through a small parallel write port. The frequency word is split into three 16-bit slices. Shadow values have no effect until an update strobe copies all of them into the active set on the same clock edge. The select input passes through two flip-flops, so a keying edge reaches the outputs after a fixed two-cycle delay. The two phase words feed sine lookup and conversion logic that sits outside this block.

Top module: `qnco_bpsk`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `phase_i` is 0 and `phase_q` is 0x400. Reset clears the accumulator, all shadow and active registers, and both select flops.
- R2: On every rising edge the accumulator advances by the active frequency word, modulo 2^48. A word of all ones makes the phase step backwards by one LSB per cycle.
- R3: A write with `wr_en` high stores `wr_data` into a shadow register. The address map is: 0 for frequency word bits [15:0], 1 for bits [31:16], 2 for bits [47:32], 3 for offset A (`wr_data[13:0]`) and 4 for offset B (`wr_data[13:0]`). A shadow write alone never changes the outputs.
- R4: On an edge where `io_update` is high, the frequency word and both offsets take the shadow values held before that edge. The accumulator uses the new word from the next edge onward.
- R5: When the delayed select is 0, offset A is applied. When it is 1, offset B is applied. The chosen offset is applied to both outputs.
- R6: A change on `bpsk_sel` before edge k reaches the outputs after edge k+1. It is not visible after edge k.
- R7: `phase_i` equals bits [47:36] of (accumulator + offset·2^34) mod 2^48.
- R8: `phase_q` equals bits [47:36] of (accumulator + ((offset + 0x1000) mod 2^14)·2^34) mod 2^48. This makes it exactly `phase_i` + 0x400 modulo 4096.
- R9: Writes to addresses 5, 6 and 7 change no register. The outputs after any later update are the same as if those writes had not occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Shadow register write enable |
| wr_addr | input | 3 | Shadow register address |
| wr_data | input | 16 | Write data |
| io_update | input | 1 | Commit all shadow registers to the active set |
| bpsk_sel | input | 1 | Offset select: 0 selects A, 1 selects B |
| phase_i | output | 12 | In-phase phase word |
| phase_q | output | 12 | Quadrature phase word |

## Verification
The embedded assertions check four things on every cycle. Active registers hold their values unless a commit occurs. A commit loads exactly the previous shadow contents. The quadrature output leads the in-phase output by exactly 0x400. With a zero word and no commit, the phase stays frozen. The exact two-edge keying delay, the address decode including the ignored addresses, and wrap-around with large frequency words can only be shown by the bench. It runs directed sequences alongside seeded random writes, commits and keying, and compares both outputs each cycle against a reference model.

// File: rtl/qnco_bpsk.sv
module qnco_bpsk #(
  parameter int ACC_W  = 48,
  parameter int OFF_W  = 14,
  parameter int OUT_W  = 12,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              io_update,
  input  logic              bpsk_sel,
  output logic [OUT_W-1:0]  phase_i,
  output logic [OUT_W-1:0]  phase_q
);
  localparam int NSLICE = ACC_W / DATA_W;
  localparam int SHIFT  = ACC_W - OFF_W;
  localparam logic [ADDR_W-1:0] ADDR_OFFA = ADDR_W'(NSLICE);
  localparam logic [ADDR_W-1:0] ADDR_OFFB = ADDR_W'(NSLICE + 1);
  localparam logic [OFF_W-1:0]  QUARTER   = OFF_W'(1) << (OFF_W - 2);

  logic [ACC_W-1:0] acc, ftw_sh, ftw_act;
  logic [OFF_W-1:0] offa_sh, offb_sh, offa_act, offb_act;
  logic             sel_s1, sel_s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_sh  <= '0;
      offa_sh <= '0;
      offb_sh <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NSLICE; k++)
        if (wr_addr == ADDR_W'(k)) ftw_sh[k*DATA_W +: DATA_W] <= wr_data;
      if (wr_addr == ADDR_OFFA) offa_sh <= wr_data[OFF_W-1:0];
      if (wr_addr == ADDR_OFFB) offb_sh <= wr_data[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_act  <= '0;
      offa_act <= '0;
      offb_act <= '0;
    end else if (io_update) begin
      ftw_act  <= ftw_sh;
      offa_act <= offa_sh;
      offb_act <= offb_sh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      sel_s1 <= 1'b0;
      sel_s2 <= 1'b0;
    end else begin
      acc    <= acc + ftw_act;
      sel_s1 <= bpsk_sel;
      sel_s2 <= sel_s1;
    end
  end

  wire [OFF_W-1:0] off_i = sel_s2 ? offb_act : offa_act;
  wire [OFF_W-1:0] off_q = off_i + QUARTER;
  wire [ACC_W-1:0] sum_i = acc + {off_i, SHIFT'(0)};
  wire [ACC_W-1:0] sum_q = acc + {off_q, SHIFT'(0)};

  assign phase_i = sum_i[ACC_W-1 -: OUT_W];
  assign phase_q = sum_q[ACC_W-1 -: OUT_W];

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !io_update |=> ($stable(ftw_act) && $stable(offa_act) && $stable(offb_act)));

  assert_commit_R4: assert property (@(posedge clk) disable iff (rst)
    io_update |=> (ftw_act == $past(ftw_sh) && offa_act == $past(offa_sh)
                   && offb_act == $past(offb_sh)));

  assert_quad_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (OUT_W'(phase_q - phase_i) == (OUT_W'(1) << (OUT_W - 2))));

  assert_freeze_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(ftw_act) == '0 && !$past(io_update) && $stable(sel_s2)) |-> $stable(phase_i));
endmodule

// File: tb/tb_qnco_bpsk.sv
module tb_qnco_bpsk;
  logic        clk = 0, rst = 1, wr_en = 0, io_update = 0, bpsk_sel = 0;
  logic [2:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [11:0] phase_i, phase_q;

  qnco_bpsk dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
                 .wr_data(wr_data), .io_update(io_update), .bpsk_sel(bpsk_sel),
                 .phase_i(phase_i), .phase_q(phase_q));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  logic [47:0] m_acc, m_ftw, m_ftw_sh;
  logic [13:0] m_oa, m_ob, m_oa_sh, m_ob_sh;
  logic        m_s1, m_s2;

  function automatic logic [11:0] f_i(logic [47:0] a, logic [13:0] o);
    logic [47:0] s = a + {o, 34'b0};
    return s[47:36];
  endfunction
  function automatic logic [11:0] f_q(logic [47:0] a, logic [13:0] o);
    logic [13:0] oq = o + 14'h1000;
    logic [47:0] s = a + {oq, 34'b0};
    return s[47:36];
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_ftw = 0; m_ftw_sh = 0; m_oa = 0; m_ob = 0;
    m_oa_sh = 0; m_ob_sh = 0; m_s1 = 0; m_s2 = 0;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    if (rst) model_reset();
    else begin
      m_acc = m_acc + m_ftw;
      m_s2 = m_s1; m_s1 = bpsk_sel;
      if (io_update) begin m_ftw = m_ftw_sh; m_oa = m_oa_sh; m_ob = m_ob_sh; end
      if (wr_en) case (wr_addr)
        3'd0: m_ftw_sh[15:0]  = wr_data;
        3'd1: m_ftw_sh[31:16] = wr_data;
        3'd2: m_ftw_sh[47:32] = wr_data;
        3'd3: m_oa_sh = wr_data[13:0];
        3'd4: m_ob_sh = wr_data[13:0];
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 0; io_update = 0;
    check({tag, " i"}, phase_i, f_i(m_acc, m_s2 ? m_ob : m_oa));
    check({tag, " q"}, phase_q, f_q(m_acc, m_s2 ? m_ob : m_oa));
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d, string tag);
    wr_en = 1; wr_addr = a; wr_data = d; step(tag);
  endtask

  task automatic commit(string tag);
    io_update = 1; step(tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [11:0] held;
    void'($urandom(32'd4242));
    model_reset();
    @(negedge clk);
    step("R1 reset");
    check("R1 reset i", phase_i, 12'h000);
    check("R1 reset q", phase_q, 12'h400);
    rst = 0;
    step("R1 first");
    check("R1 first i", phase_i, 12'h000);

    wr(3, 16'h0000, "R3 wa"); wr(4, 16'h2000, "R3 wb"); commit("R4 c0");
    step("R5 a");
    check("R5 offset A i", phase_i, 12'h000);
    bpsk_sel = 1;
    step("R6 e1");
    check("R6 not after one edge", phase_i, 12'h000);
    step("R6 e2");
    check("R5 R6 offset B after two edges", phase_i, 12'h800);
    check("R8 quadrature with B", phase_q, 12'hC00);

    held = phase_i;
    wr(4, 16'h1000, "R3 w");
    step("R3 h1"); step("R3 h2");
    check("R3 shadow write has no effect", phase_i, held);
    commit("R4 c1"); step("R4 after");
    check("R4 commit applies B", phase_i, 12'h400);

    wr(5, 16'hFFFF, "R9 w5"); wr(6, 16'h1234, "R9 w6"); wr(7, 16'h3FFF, "R9 w7");
    commit("R9 c"); step("R9 after");
    check("R9 ignored addresses", phase_i, 12'h400);

    wr(0, 16'hFFFF, "R2 w0"); wr(1, 16'hFFFF, "R2 w1"); wr(2, 16'hFFFF, "R2 w2");
    commit("R2 wrap c");
    for (int n = 0; n < 4; n++) step("R2 R7 wrap");
    wr(0, 16'h0000, "R2 w0"); wr(1, 16'h0000, "R2 w1"); wr(2, 16'h0100, "R2 w2");
    commit("R2 step c");
    for (int n = 0; n < 20; n++) step("R2 R7 R8 advance");

    for (int n = 0; n < 600; n++) begin
      wr_en = ($urandom % 3) == 0;
      wr_addr = 3'($urandom);
      wr_data = 16'($urandom);
      io_update = ($urandom % 6) == 0;
      if (($urandom % 5) == 0) bpsk_sel = ~bpsk_sel;
      step("R2 R4 R5 R7 R8 random");
    end

    rst = 1; step("R1 re-reset");
    check("R1 re-reset q", phase_q, 12'h400);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule